// File: doc/BRIEF.md
# Per-Channel Window Comparator with Deglitch Filter

This block watches a stream of corrected conversion samples that arrive for eight input channels, one sample per valid strobe with a channel index. For each channel it compares the upper eight bits of the sample against that channel's own upper and lower limit. When a channel leaves its window for long enough, the block latches a flag for that direction, and the flag stays set until a clear pulse arrives.

Two mechanisms reject noise. The first is a shared run-length filter: a flag is only raised after a set number of consecutive out-of-window samples for that channel and direction. The second is a per-channel hysteresis band: once a direction has fired, it cannot count again until the sample has come back inside the limit by at least the hysteresis amount. The flags are collected into a single 16-bit status word that a register bank or interrupt controller elsewhere reads.

Top module: `win_cmp_top`

## Requirements
- R1: After reset deassertion `flag_o` is 0 and all directions are armed with zero run counts.
- R2: A sample counts as a high violation when its bits 15:8, taken as unsigned, are strictly greater than the channel's high limit; bits 7:0 of the sample have no effect (0xA0FF against a limit of 0xA0 does not trip, 0xA100 does).
- R3: A sample counts as a low violation when its bits 15:8, taken as unsigned, are strictly less than the channel's low limit.
- R4: A flag is set only after `filt_i` consecutive violating samples of one channel in one direction; a sample of that channel inside the limit restarts the run, while idle cycles and samples of other channels do not.
- R5: A filter setting of 0 acts like 1: one violating sample sets the flag.
- R6: A channel whose enable bit is 0 never sets a flag, and while disabled its run counts are cleared and both directions re-armed.
- R7: Flag word layout: bit 15-c is the high flag of channel c and bit 7-c is its low flag. Channel c's limits and hysteresis sit in bits 8c+7:8c of `hi_th_i`, `lo_th_i` and `hyst_i`, and its enable is `ch_en_i[c]`.
- R8: Flags are sticky; a `clr_i` cycle makes `flag_o` zero on the next cycle and wins over a flag that would be set in the same cycle.
- R9: After a direction fires it is disarmed; the high direction re-arms on a sample with top8 + hysteresis <= high limit, the low direction on a sample with top8 >= low limit + hysteresis (9-bit sums), and only samples after the re-arming one count.
- R10: A sample violating one direction restarts the run of the opposite direction of the same channel.
- R11: With neutral limits (high 0xFF, low 0x00) no sample can set a flag.
- R12: A flag appears in the cycle after the clock edge that takes in the violating sample and is not visible during the sample's own valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_ch_i | input | 3 | Channel index of the sample |
| smp_data_i | input | 16 | Corrected sample |
| ch_en_i | input | 8 | Per-channel enable |
| hi_th_i | input | 64 | Per-channel high limits, 8 bits each |
| lo_th_i | input | 64 | Per-channel low limits, 8 bits each |
| hyst_i | input | 64 | Per-channel hysteresis, 8 bits each |
| filt_i | input | 4 | Consecutive-sample count needed to set a flag |
| clr_i | input | 1 | Clears all flags and run counts |
| flag_o | output | 16 | High flags in 15:8, low flags in 7:0 |

## Verification
The bench builds the block with its default parameters: eight channels, 16-bit samples, 8-bit limits and a 4-bit filter field. That size lets every flag bit be reached and places the channel-to-bit order at both ends of each byte. Filter settings of 0, 1, 2 and 3 are used, which is enough to show run restarts by inside samples and by opposite-direction samples. Hysteresis is tested at exactly the re-arm boundary and one step short of it, in both directions.

// File: rtl/win_cmp_pkg.sv
package win_cmp_pkg;
  localparam int unsigned DEF_NUM_CH = 8;
  localparam int unsigned DEF_SMP_W  = 16;
  localparam int unsigned DEF_TH_W   = 8;
  localparam int unsigned DEF_FILT_W = 4;

  typedef enum logic {
    DIR_LOW  = 1'b0,
    DIR_HIGH = 1'b1
  } win_dir_e;
endpackage

// File: rtl/win_cmp_dir.sv
module win_cmp_dir
  import win_cmp_pkg::*;
#(
  parameter win_dir_e    DIR    = DIR_HIGH,
  parameter int unsigned TH_W   = DEF_TH_W,
  parameter int unsigned FILT_W = DEF_FILT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hit_i,
  input  logic              clr_i,
  input  logic [TH_W-1:0]   top_i,
  input  logic [TH_W-1:0]   th_i,
  input  logic [TH_W-1:0]   hyst_i,
  input  logic [FILT_W-1:0] need_i,
  output logic              viol_o,
  input  logic              opp_viol_i,
  output logic              flag_o
);
  logic [FILT_W-1:0] cnt_q;
  logic              armed_q, flag_q;
  logic              viol, rearm_ok;
  logic [TH_W:0]     top_x, th_x, hy_x;
  logic [FILT_W:0]   cnt_nx;

  assign top_x  = {1'b0, top_i};
  assign th_x   = {1'b0, th_i};
  assign hy_x   = {1'b0, hyst_i};
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;

  if (DIR == DIR_HIGH) begin : g_high
    assign viol     = top_i > th_i;
    assign rearm_ok = (top_x + hy_x) <= th_x;
  end else begin : g_low
    assign viol     = top_i < th_i;
    assign rearm_ok = top_x >= (th_x + hy_x);
  end

  assign viol_o = viol;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      if (!en_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (hit_i) begin
        if (!armed_q) begin
          cnt_q <= '0;
          if (rearm_ok) armed_q <= 1'b1;
        end else if (viol && !opp_viol_i) begin
          if (cnt_nx >= {1'b0, need_i}) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            flag_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_nx[FILT_W-1:0];
          end
        end else begin
          cnt_q <= '0;
        end
      end
      if (clr_i) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/win_cmp_chan.sv
module win_cmp_chan
  import win_cmp_pkg::*;
#(
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned TH_W   = DEF_TH_W,
  parameter int unsigned FILT_W = DEF_FILT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hit_i,
  input  logic              clr_i,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [TH_W-1:0]   hi_th_i,
  input  logic [TH_W-1:0]   lo_th_i,
  input  logic [TH_W-1:0]   hyst_i,
  input  logic [FILT_W-1:0] need_i,
  output logic              hi_flag_o,
  output logic              lo_flag_o
);
  logic [TH_W-1:0] top;
  logic            hi_viol, lo_viol;

  assign top = smp_i[SMP_W-1 -: TH_W];

  win_cmp_dir #(.DIR(DIR_HIGH), .TH_W(TH_W), .FILT_W(FILT_W)) u_hi (
    .clk_i, .rst_ni, .en_i, .hit_i, .clr_i,
    .top_i(top), .th_i(hi_th_i), .hyst_i, .need_i,
    .viol_o(hi_viol), .opp_viol_i(lo_viol), .flag_o(hi_flag_o)
  );

  win_cmp_dir #(.DIR(DIR_LOW), .TH_W(TH_W), .FILT_W(FILT_W)) u_lo (
    .clk_i, .rst_ni, .en_i, .hit_i, .clr_i,
    .top_i(top), .th_i(lo_th_i), .hyst_i, .need_i,
    .viol_o(lo_viol), .opp_viol_i(hi_viol), .flag_o(lo_flag_o)
  );
endmodule

// File: rtl/win_cmp_top.sv
module win_cmp_top
  import win_cmp_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned TH_W   = DEF_TH_W,
  parameter int unsigned FILT_W = DEF_FILT_W,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned CFG_W = NUM_CH * TH_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_valid_i,
  input  logic [CH_W-1:0]     smp_ch_i,
  input  logic [SMP_W-1:0]    smp_data_i,
  input  logic [NUM_CH-1:0]   ch_en_i,
  input  logic [CFG_W-1:0]    hi_th_i,
  input  logic [CFG_W-1:0]    lo_th_i,
  input  logic [CFG_W-1:0]    hyst_i,
  input  logic [FILT_W-1:0]   filt_i,
  input  logic                clr_i,
  output logic [2*NUM_CH-1:0] flag_o
);
  logic [FILT_W-1:0] need;
  logic [NUM_CH-1:0] hi_flag, lo_flag;

  // setting 0 means a single sample
  assign need = (filt_i == '0) ? FILT_W'(1) : filt_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = smp_valid_i && (smp_ch_i == CH_W'(c));

    win_cmp_chan #(.SMP_W(SMP_W), .TH_W(TH_W), .FILT_W(FILT_W)) u_chan (
      .clk_i, .rst_ni,
      .en_i     (ch_en_i[c]),
      .hit_i    (hit),
      .clr_i,
      .smp_i    (smp_data_i),
      .hi_th_i  (hi_th_i[c*TH_W +: TH_W]),
      .lo_th_i  (lo_th_i[c*TH_W +: TH_W]),
      .hyst_i   (hyst_i[c*TH_W +: TH_W]),
      .need_i   (need),
      .hi_flag_o(hi_flag[c]),
      .lo_flag_o(lo_flag[c])
    );

    // channel 0 sits in the MSB of each byte
    assign flag_o[2*NUM_CH-1-c] = hi_flag[c];
    assign flag_o[NUM_CH-1-c]   = lo_flag[c];
  end
endmodule

// File: rtl/win_cmp_chk.sv
module win_cmp_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                smp_valid_i,
  input logic [CH_W-1:0]     smp_ch_i,
  input logic [NUM_CH-1:0]   ch_en_i,
  input logic                clr_i,
  input logic [2*NUM_CH-1:0] flag_o
);
  logic [NUM_CH-1:0] ch_bit;
  assign ch_bit = ({{(NUM_CH-1){1'b0}}, 1'b1} << (NUM_CH-1)) >> smp_ch_i;

  // R8: clear zeroes every flag on the next cycle
  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flag_o == '0));

  // R8: no flag drops without a clear
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

  // R4: without a sample nothing changes
  a_r4_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !clr_i) |=> $stable(flag_o));

  // R6: disabled channel sample changes nothing
  a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !ch_en_i[smp_ch_i] && !clr_i) |=> $stable(flag_o));

  // R7: a new flag belongs to the sampled channel
  a_r7_bit_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> ((flag_o & ~$past(flag_o) & ~{$past(ch_bit), $past(ch_bit)}) == '0));
endmodule

bind win_cmp_top win_cmp_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .smp_ch_i(smp_ch_i),
  .ch_en_i(ch_en_i), .clr_i(clr_i), .flag_o(flag_o)
);

// File: tb/win_cmp_top_tb_top.sv
module win_cmp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  ch = '0;
  logic [15:0] data = '0;
  logic [7:0]  en = '0;
  logic [63:0] hi_th = {8{8'hFF}};
  logic [63:0] lo_th = '0;
  logic [63:0] hyst = '0;
  logic [3:0]  filt = '0;
  logic        clr = 1'b0;
  logic [15:0] flag;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  win_cmp_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_ch_i(ch),
    .smp_data_i(data), .ch_en_i(en), .hi_th_i(hi_th), .lo_th_i(lo_th),
    .hyst_i(hyst), .filt_i(filt), .clr_i(clr), .flag_o(flag)
  );

  task automatic chk(input string req, input logic [15:0] exp);
    total++;
    if (flag !== exp) begin
      bad++;
      $display("FAIL %s: flag=%h expected=%h", req, flag, exp);
    end
  endtask

  task automatic put(input int c, input logic [15:0] d);
    @(negedge clk);
    valid = 1'b1; ch = c[2:0]; data = d;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", 16'h0000);
  endtask

  task automatic t_neutral();
    en = 8'hFF; filt = 4'd1;
    put(3, 16'hFFFF); put(3, 16'h0000); put(0, 16'hFFFF);
    chk("R11 neutral limits", 16'h0000);
  endtask

  task automatic set_window();
    hi_th = {8{8'hA0}}; lo_th = {8{8'h20}}; hyst = {8{8'h10}};
  endtask

  task automatic t_compare();
    put(2, 16'hA0FF);
    chk("R2 equal top byte, low bits ignored", 16'h0000);
    @(negedge clk); valid = 1'b1; ch = 3'd2; data = 16'hA100;
    #1 chk("R12 not visible in valid cycle", 16'h0000);
    @(negedge clk); valid = 1'b0;
    chk("R2 R7 R12 high flag ch2", 16'h2000);
    do_clear();
    chk("R8 cleared", 16'h0000);
  endtask

  task automatic t_low();
    put(6, 16'h2000);
    chk("R3 equal low limit", 16'h0000);
    put(5, 16'h1FFF);
    chk("R3 R7 low flag ch5", 16'h0004);
    do_clear();
  endtask

  task automatic t_filter();
    filt = 4'd3;
    put(0, 16'hA100); put(0, 16'hA100); put(1, 16'h5000);
    repeat (3) @(negedge clk);
    chk("R4 two of three", 16'h0000);
    put(0, 16'hA100);
    chk("R4 third sample sets ch0", 16'h8000);
    put(7, 16'hA100); put(7, 16'hA100); put(7, 16'h5000);
    put(7, 16'hA100); put(7, 16'hA100);
    chk("R4 inside sample restarts run", 16'h8000);
    put(7, 16'hA100);
    chk("R4 ch7 after full run", 16'h8100);
    put(4, 16'h1000); put(4, 16'h1000); put(4, 16'hB000);
    put(4, 16'h1000); put(4, 16'h1000);
    chk("R10 high sample restarts low run", 16'h8100);
    put(4, 16'h1000);
    chk("R10 low flag ch4", 16'h8108);
    do_clear();
  endtask

  task automatic t_filt0();
    filt = 4'd0;
    put(1, 16'hFF00);
    chk("R5 setting zero acts as one", 16'h4000);
    do_clear();
  endtask

  task automatic t_disable();
    filt = 4'd2;
    en = 8'hEF ^ 8'h01 ^ 8'h01; // ch4 used later only when enabled
    en[3] = 1'b0;
    put(3, 16'hFF00); put(3, 16'hFF00); put(3, 16'hFF00);
    chk("R6 disabled channel", 16'h0000);
    en[3] = 1'b1;
    put(3, 16'hA100);
    @(negedge clk); en[3] = 1'b0;
    @(negedge clk); en[3] = 1'b1;
    put(3, 16'hA100);
    chk("R6 disable clears run", 16'h0000);
    put(3, 16'hA100);
    chk("R6 ch3 sets after fresh run", 16'h1000);
    en = 8'hFF;
    do_clear();
  endtask

  task automatic t_sticky();
    filt = 4'd1;
    put(6, 16'hB000);
    put(6, 16'h5000); put(6, 16'h5000); put(1, 16'h5000);
    chk("R8 sticky after inside samples", 16'h0200);
    @(negedge clk);
    clr = 1'b1; valid = 1'b1; ch = 3'd0; data = 16'h0000;
    @(negedge clk);
    clr = 1'b0; valid = 1'b0;
    chk("R8 clear wins over set", 16'h0000);
  endtask

  task automatic t_hyst();
    put(2, 16'hB000);
    chk("R9 disarmed high", 16'h0000);
    put(2, 16'h9100); put(2, 16'hB000);
    chk("R9 short of high band", 16'h0000);
    put(2, 16'h9000); put(2, 16'hB000);
    chk("R9 high re-armed at boundary", 16'h2000);
    put(5, 16'h0000);
    chk("R9 disarmed low", 16'h2000);
    put(5, 16'h2F00); put(5, 16'h0000);
    chk("R9 short of low band", 16'h2000);
    put(5, 16'h3000); put(5, 16'h0000);
    chk("R9 low re-armed at boundary", 16'h2004);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: flag=%h expected=run end", flag);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_neutral();
    set_window();
    t_compare();
    t_low();
    t_filter();
    t_filt0();
    t_disable();
    t_sticky();
    t_hyst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule